// File: doc/BRIEF.md
# Programmable Counter/Timer with Square-Wave Output

This block is a 16-bit down-counter for a serial-port peripheral. It has two modes. In timer mode it divides a counter clock, supplied as a one-cycle enable `tick_i`, by a programmable preload and produces a square wave suitable as a baud-rate clock. In counter mode it counts down once from the preload and reports when it reaches zero.

The CPU writes the preload one byte at a time into two write-only byte registers. The same two addresses, when read, return the live count. Two further read addresses act as commands. A read at 0xE restarts the block from the preload and latches the mode selected on `mode_sel_i`. A read at 0xF clears the ready flag, and in counter mode it also halts the count.

After reset the block runs in timer mode. In timer mode it can be restarted but never halted. Clock-source selection and pin routing sit outside this block.

Top module: `prog_ctr_timer`

## Requirements
- R1: After reset the mode is timer and the block is counting. `wave_o` is 1, `rdy_o` is 0 and the count equals the reset preload (default 0x0010).
- R2: A write at address 0x6 sets the preload's upper byte and a write at 0x7 sets its lower byte. Reads at these addresses never return the preload.
- R3: In timer mode, `wave_o` toggles after every P ticks, where P is the preload in effect. The period is therefore 2·P ticks.
- R4: In timer mode, a preload written during a half-period does not change that half-period. It is used from the next reload onward.
- R5: A read at 0xE (start) loads the count from the preload, drives `wave_o` to 1 and latches `mode_sel_i` (0 selects timer, 1 selects counter). If a tick arrives in the same cycle, the start wins.
- R6: In timer mode, `rdy_o` is set once per square-wave cycle, when `wave_o` returns high. A read at 0xF (stop) clears `rdy_o` and does not pause the timer. If a set and a stop occur in the same cycle, the set wins.
- R7: In counter mode, the count falls by one on each tick. When it reaches 0x0000, `rdy_o` is set and `wave_o` goes low. Counting continues past zero and wraps to 0xFFFF.
- R8: In counter mode, a stop halts the count, returns `wave_o` to 1 and clears `rdy_o`.
- R9: In counter mode, a preload write has no effect until the next start. A start with no new write reuses the previous preload.
- R10: While `rd_en_i` is high, `rdata_o` returns the live count's upper byte at address 0x6 and its lower byte at 0x7. Every other read address, and any cycle without a read, returns 0x00.
- R11: A change on `mode_sel_i` has no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable from the counter clock source |
| mode_sel_i | input | 1 | Mode for the next start: 0 timer, 1 counter |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; start and stop commands are decoded from it |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| rdy_o | output | 1 | Counter-ready status |
| wave_o | output | 1 | Square wave in timer mode, terminal-count flag in counter mode |

## Verification
A corrupted count or a wrong reload value shows up in two ways. The next count read at 0x6/0x7 returns the wrong byte. In timer mode, `wave_o` toggles at the wrong tick within a single half-period. A wrongly latched mode, or a lost running flag, shows up as a halted or still-running count within one tick after a stop. A ready-flag fault shows in the cycle after the tick or stop that should have set or cleared it. The bench compares all three outputs with its reference model on every clock, so each of these faults is caught within a few cycles of its cause.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
   typedef enum logic {
      MODE_TIMER   = 1'b0,
      MODE_COUNTER = 1'b1
   } ctr_mode_e;
endpackage

// File: rtl/ctr_preload_regs.sv
module ctr_preload_regs #(
   parameter int CNT_W     = 16,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 4,
   parameter int BASE_ADDR = 6,
   parameter logic [CNT_W-1:0] RST_VAL = 16'h0010
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [CNT_W-1:0]  preload_o
);
   localparam int NBYTES = CNT_W / DATA_W;

   for (genvar k = 0; k < NBYTES; k++) begin : g_byte
      localparam logic [ADDR_W-1:0] BYTE_ADDR = ADDR_W'(BASE_ADDR + NBYTES - 1 - k);
      logic [DATA_W-1:0] byte_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            byte_q <= RST_VAL[k*DATA_W +: DATA_W];
         end else if (wr_en_i && (addr_i == BYTE_ADDR)) begin
            byte_q <= wdata_i;
         end
      end

      assign preload_o[k*DATA_W +: DATA_W] = byte_q;
   end
endmodule

// File: rtl/ctr_cmd_decode.sv
module ctr_cmd_decode #(
   parameter int CNT_W      = 16,
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 4,
   parameter int BASE_ADDR  = 6,
   parameter int START_ADDR = 14,
   parameter int STOP_ADDR  = 15
) (
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic              start_o,
   output logic              stop_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int NBYTES = CNT_W / DATA_W;
   localparam logic [ADDR_W-1:0] START_A = ADDR_W'(START_ADDR);
   localparam logic [ADDR_W-1:0] STOP_A  = ADDR_W'(STOP_ADDR);

   assign start_o = rd_en_i && (addr_i == START_A);
   assign stop_o  = rd_en_i && (addr_i == STOP_A);

   always_comb begin
      rdata_o = '0;
      if (rd_en_i) begin
         for (int k = 0; k < NBYTES; k++) begin
            if (addr_i == ADDR_W'(BASE_ADDR + NBYTES - 1 - k)) begin
               rdata_o = cnt_i[k*DATA_W +: DATA_W];
            end
         end
      end
   end
endmodule

// File: rtl/ctr_core.sv
module ctr_core
   import ctr_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter logic [CNT_W-1:0] RST_VAL = 16'h0010
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             mode_sel_i,
   input  logic [CNT_W-1:0] preload_i,
   output logic [CNT_W-1:0] cnt_o,
   output ctr_mode_e        mode_o,
   output logic             run_o,
   output logic             wave_o,
   output logic             rdy_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   ctr_mode_e        mode_q;
   logic             run_q, wave_q, rdy_q;
   logic             halt_cmd, step, at_last, set_evt;

   assign halt_cmd = stop_i && (mode_q == MODE_COUNTER);
   assign step     = !start_i && !halt_cmd && tick_i && run_q;
   assign at_last  = (cnt_q == ONE);
   assign set_evt  = step && at_last && ((mode_q == MODE_COUNTER) || !wave_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= RST_VAL;
         mode_q <= MODE_TIMER;
         run_q  <= 1'b1;
         wave_q <= 1'b1;
      end else if (start_i) begin
         cnt_q  <= preload_i;
         mode_q <= ctr_mode_e'(mode_sel_i);
         run_q  <= 1'b1;
         wave_q <= 1'b1;
      end else if (halt_cmd) begin
         run_q  <= 1'b0;
         wave_q <= 1'b1;
      end else if (step) begin
         if (mode_q == MODE_TIMER) begin
            if (at_last) begin
               cnt_q  <= preload_i;
               wave_q <= ~wave_q;
            end else begin
               cnt_q <= cnt_q - ONE;
            end
         end else begin
            cnt_q <= cnt_q - ONE;
            if (at_last) begin
               wave_q <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdy_q <= 1'b0;
      end else if (set_evt) begin
         rdy_q <= 1'b1;
      end else if (stop_i) begin
         rdy_q <= 1'b0;
      end
   end

   assign cnt_o  = cnt_q;
   assign mode_o = mode_q;
   assign run_o  = run_q;
   assign wave_o = wave_q;
   assign rdy_o  = rdy_q;
endmodule

// File: rtl/prog_ctr_timer.sv
module prog_ctr_timer
   import ctr_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 4,
   parameter int BASE_ADDR  = 6,
   parameter int START_ADDR = 14,
   parameter int STOP_ADDR  = 15,
   parameter logic [CNT_W-1:0] RST_VAL = 16'h0010
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              mode_sel_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rdy_o,
   output logic              wave_o
);
   localparam int NBYTES = CNT_W / DATA_W;

   if (CNT_W != NBYTES * DATA_W) begin : g_bad_width
      $error("CNT_W must be a whole number of DATA_W bytes");
   end
   if (RST_VAL < CNT_W'(2)) begin : g_bad_rst
      $error("reset preload must be at least 2");
   end
   if (START_ADDR == STOP_ADDR) begin : g_bad_cmd
      $error("start and stop addresses must differ");
   end
   if ((START_ADDR >= BASE_ADDR && START_ADDR < BASE_ADDR + NBYTES) ||
       (STOP_ADDR >= BASE_ADDR && STOP_ADDR < BASE_ADDR + NBYTES)) begin : g_bad_map
      $error("command addresses overlap the count bytes");
   end

   logic [CNT_W-1:0] preload_w, cnt_w;
   logic             start_w, stop_w, run_w;
   ctr_mode_e        mode_w;

   ctr_preload_regs #(
      .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .BASE_ADDR(BASE_ADDR), .RST_VAL(RST_VAL)
   ) u_pre (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .preload_o(preload_w)
   );

   ctr_cmd_decode #(
      .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .BASE_ADDR(BASE_ADDR), .START_ADDR(START_ADDR), .STOP_ADDR(STOP_ADDR)
   ) u_dec (
      .rd_en_i(rd_en_i), .addr_i(addr_i), .cnt_i(cnt_w),
      .start_o(start_w), .stop_o(stop_w), .rdata_o(rdata_o)
   );

   ctr_core #(
      .CNT_W(CNT_W), .RST_VAL(RST_VAL)
   ) u_core (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
      .start_i(start_w), .stop_i(stop_w), .mode_sel_i(mode_sel_i),
      .preload_i(preload_w), .cnt_o(cnt_w), .mode_o(mode_w),
      .run_o(run_w), .wave_o(wave_o), .rdy_o(rdy_o)
   );
endmodule

// File: rtl/ctr_checker.sv
module ctr_checker
   import ctr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              tick_i,
   input logic              rd_en_i,
   input logic              start_i,
   input logic              stop_i,
   input logic [CNT_W-1:0]  preload_i,
   input logic [CNT_W-1:0]  cnt_i,
   input ctr_mode_e         mode_i,
   input logic              run_i,
   input logic              wave_i,
   input logic              rdy_i,
   input logic [DATA_W-1:0] rdata_i
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assert_start_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (cnt_i == $past(preload_i)) && wave_i && run_i);

   assert_timer_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_TIMER && tick_i && !start_i && cnt_i != ONE)
      |=> (cnt_i == $past(cnt_i) - ONE) && $stable(wave_i));

   assert_timer_runs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_TIMER) |-> run_i);

   assert_stop_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_i && !tick_i) |=> !rdy_i);

   assert_rdy_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rdy_i) |-> $past(tick_i));

   assert_terminal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_COUNTER && run_i && tick_i && !start_i && !stop_i && cnt_i == ONE)
      |=> (!wave_i && rdy_i && cnt_i == '0));

   assert_halted_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_COUNTER && !run_i && !start_i) |=> $stable(cnt_i) && wave_i);

   assert_read_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |-> (rdata_i == '0));

   assert_mode_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> $stable(mode_i));
endmodule

bind prog_ctr_timer ctr_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rd_en_i(rd_en_i),
   .start_i(start_w), .stop_i(stop_w), .preload_i(preload_w), .cnt_i(cnt_w),
   .mode_i(mode_w), .run_i(run_w), .wave_i(wave_o), .rdy_i(rdy_o),
   .rdata_i(rdata_o)
);

// File: tb/tb_prog_ctr_timer.sv
`timescale 1ns/1ps
module tb_prog_ctr_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, mode_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0] addr = 4'h0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       rdy, wave;

   int n_checks = 0, n_fail = 0;
   bit done = 0;

   // reference model state
   int m_cnt = 16, m_pre = 16, m_wave = 1, m_rdy = 0, m_mode = 0, m_run = 1;

   always #5 clk = ~clk;

   prog_ctr_timer dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_sel_i(mode_sel),
      .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .rdy_o(rdy), .wave_o(wave)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference, evaluated at each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 16; m_pre = 16; m_wave = 1; m_rdy = 0; m_mode = 0; m_run = 1;
      end else begin
         int  old_pre;
         bit  st, sp, setf;
         old_pre = m_pre;
         st = rd_en && addr == 4'hE;
         sp = rd_en && addr == 4'hF;
         setf = 0;
         if (st) begin
            m_mode = int'(mode_sel); m_cnt = old_pre; m_wave = 1; m_run = 1;
         end else if (sp && m_mode == 1) begin
            m_run = 0; m_wave = 1;
         end else if (tick && m_run == 1) begin
            if (m_mode == 0) begin
               if (m_cnt == 1) begin
                  if (m_wave == 0) setf = 1;
                  m_cnt = old_pre; m_wave = 1 - m_wave;
               end else m_cnt = m_cnt - 1;
            end else begin
               if (m_cnt == 1) begin setf = 1; m_wave = 0; end
               m_cnt = (m_cnt + 65535) % 65536;
            end
         end
         if (setf) m_rdy = 1;
         else if (sp) m_rdy = 0;
         if (wr_en && addr == 4'h6) m_pre = (m_pre & 255) | (int'(wdata) << 8);
         if (wr_en && addr == 4'h7) m_pre = (m_pre & 65280) | int'(wdata);
      end
   end

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int exp_rd;
         exp_rd = 0;
         if (rd_en && addr == 4'h6) exp_rd = (m_cnt >> 8) & 255;
         if (rd_en && addr == 4'h7) exp_rd = m_cnt & 255;
         chk("R3 wave vs model", int'(wave), m_wave);
         chk("R6 rdy vs model", int'(rdy), m_rdy);
         chk("R10 rdata vs model", int'(rdata), exp_rd);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      cyc(1);
      wr_en = 1'b0; addr = 4'h0;
   endtask

   task automatic rd(input logic [3:0] a, output int v);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      v = int'(rdata);
      #1;
      rd_en = 1'b0; addr = 4'h0;
   endtask

   task automatic count_toggles(input int n, output int t);
      logic prev;
      t = 0;
      prev = wave;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (wave !== prev) t++;
         prev = wave;
      end
      #1;
   endtask

   initial begin : watchdog
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      int v, v2, t;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1: reset state
      chk("R1 wave after reset", int'(wave), 1);
      chk("R1 rdy after reset", int'(rdy), 0);
      rd(4'h7, v); chk("R1 count low after reset", v, 16'h10 & 255);
      rd(4'h6, v); chk("R1 count high after reset", v, 0);
      // R2: preload bytes are write-only
      wr(4'h6, 8'h00); wr(4'h7, 8'h03);
      rd(4'h7, v); chk("R2 read is count not preload", v, 8'h10);
      // R5: start loads preload
      rd(4'hE, v);
      rd(4'h7, v); chk("R5 start loads preload", v, 3);
      // R3: period 6 with ticks every cycle
      tick = 1'b1;
      count_toggles(12, t); chk("R3 toggles in 12 ticks, P=3", t, 4);
      // R4: preload change applies from next half-period
      wr(4'h7, 8'h05);
      cyc(8);
      count_toggles(20, t); chk("R4 toggles in 20 ticks, P=5", t, 4);
      // R6: stop clears ready, timer keeps running
      cyc(12);
      tick = 1'b0;
      chk("R6 ready set after full cycles", int'(rdy), 1);
      rd(4'hF, v);
      chk("R6 stop clears ready", int'(rdy), 0);
      tick = 1'b1;
      count_toggles(20, t); chk("R6 timer still running after stop", t, 4);
      // R11: mode select ignored until start
      mode_sel = 1'b1;
      count_toggles(20, t); chk("R11 mode_sel without start keeps timer", t, 4);
      // R10: unmapped read
      rd(4'h3, v); chk("R10 unmapped read", v, 0);
      // R7: counter mode terminal count and wrap
      tick = 1'b0;
      wr(4'h7, 8'h02);
      rd(4'hE, v);
      chk("R7 wave high after start", int'(wave), 1);
      tick = 1'b1;
      cyc(6);
      chk("R7 wave low at terminal count", int'(wave), 0);
      chk("R7 ready at terminal count", int'(rdy), 1);
      rd(4'h6, v); chk("R7 wrap past zero", v, 8'hFF);
      // R9: preload write ignored while counting
      wr(4'h6, 8'h05); wr(4'h7, 8'h00);
      rd(4'h6, v); chk("R9 new preload not applied", v, 8'hFF);
      // R8: stop halts, wave high, ready cleared
      rd(4'hF, v);
      chk("R8 wave high after stop", int'(wave), 1);
      chk("R8 ready cleared by stop", int'(rdy), 0);
      rd(4'h7, v);
      cyc(5);
      rd(4'h7, v2); chk("R8 count halted", v2, v);
      // R9: next start uses new preload; later start reuses it
      tick = 1'b0;
      rd(4'hE, v);
      rd(4'h6, v); chk("R9 start applies new preload", v, 8'h05);
      tick = 1'b1; cyc(7); tick = 1'b0;
      rd(4'hF, v);
      rd(4'hE, v);
      rd(4'h6, v); chk("R9 start reuses preload", v, 8'h05);
      // sparse ticks back in timer mode, compared by model
      mode_sel = 1'b0;
      wr(4'h7, 8'h04); wr(4'h6, 8'h00);
      rd(4'hE, v);
      for (int i = 0; i < 120; i++) begin
         tick = (i % 3 == 0);
         cyc(1);
      end
      tick = 1'b0;
      cyc(2);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule